// File: doc/BRIEF.md
# Streaming UDP Datagram Transmitter

This block turns a command and a stream of payload bytes into a complete UDP datagram (UDP header, payload, two-byte trailer) on a byte-wide valid/ready output. The checksum field of the header is sent as a constant fixed by a parameter, before any payload has been seen. Each payload byte goes straight from the input to the output in the cycle it is accepted, so nothing is stored. Samples that reach the input while a datagram is already on the wire still end up in it. A running ones' complement sum covers the pseudo-header, the UDP header and every payload byte. After the last payload byte the block emits the bitwise complement of that sum as a trailer, so the whole datagram verifies against the constant already sent.

A command carries the IPv4 source and destination addresses, the two port numbers and the payload byte count. The block accepts it only when idle. The surrounding logic wraps the output in an IPv4 header and an Ethernet frame. The UDP length field, and the length the IPv4 layer must use, is the payload count plus ten. The payload count must be even, so the trailer lands on a 16-bit boundary.

Top module: `udp_stream_tx`

## Requirements
- R1: A datagram starts with eight header bytes: source port, destination port, UDP length, checksum field, each a 16-bit word sent high byte first. The UDP length equals the even payload count plus 10.
- R2: Header bytes 6 and 7 always carry the parameter CSUM_CONST, high byte first, whatever the payload. CSUM_CONST may not be zero.
- R3: Payload bytes leave in arrival order and unchanged. During the payload phase in_ready equals out_ready and out_valid equals in_valid.
- R4: Two trailer bytes follow the payload. The 16-bit ones' complement sum (end-around carry) over the pseudo-header (source address, destination address, 0x0011, UDP length) and every datagram byte, paired big-endian, equals 0xFFFF.
- R5: out_last is high on the second trailer byte and on no other byte.
- R6: While out_valid is high and out_ready is low, the output byte is held and the datagram does not advance. Backpressure does not change the byte sequence.
- R7: A payload count of zero yields the header followed directly by the trailer, 10 bytes in all.
- R8: Bit 0 of the payload count is ignored: an odd count N gives N-1 payload bytes and a UDP length of N+9.
- R9: cmd_ready is high only when no datagram is in progress. A command is taken when cmd_valid and cmd_ready are both high, and its fields are sampled in that cycle.
- R10: After reset cmd_ready is 1, out_valid is 0 and in_ready is 0.
- R11: A pause in the payload source (in_valid low) leaves out_valid low, and the paused cycles add nothing to the datagram.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command will be taken |
| cmd_src_ip | input | 32 | IPv4 source address for the pseudo-header |
| cmd_dst_ip | input | 32 | IPv4 destination address for the pseudo-header |
| cmd_src_port | input | 16 | UDP source port |
| cmd_dst_port | input | 16 | UDP destination port |
| cmd_pay_len | input | LEN_W | Payload byte count (bit 0 ignored) |
| in_valid | input | 1 | Payload byte present |
| in_ready | output | 1 | Payload byte accepted this cycle |
| in_data | input | 8 | Payload byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Datagram byte |
| out_last | output | 1 | Final byte of the datagram |

## Verification
The datagrams differ in payload length: eight bytes, zero bytes, an odd count, a long run near the largest count, and mid-size runs. The zero and odd counts show whether the phase sequencing and the length rounding are right independently of the summing. Identical payloads are sent with a steady sink, with a random stalling sink and with a source that pauses. This shows whether the running sum and the byte counter move only on real transfers. Every datagram is checked byte by byte against a model and then checksummed as a receiver would. A wrong byte-pair alignment or a lost carry shows up as a sum other than 0xFFFF even when every header byte matches.

// File: rtl/udp_stx_pkg.sv
package udp_stx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HDR  = 2'd1,
      ST_PAY  = 2'd2,
      ST_TRL  = 2'd3
   } stx_state_e;

   localparam logic [15:0] IP_PROTO_UDP  = 16'h0011;
   localparam int          UDP_HDR_BYTES = 8;
   localparam int          TRL_BYTES     = 2;

   // 16-bit ones' complement addition with end-around carry
   function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
      logic [16:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[15:0] + {15'd0, s[16]};
   endfunction

endpackage

// File: rtl/udp_stx_csum.sv
module udp_stx_csum
   import udp_stx_pkg::*;
#(
   parameter logic [15:0] CSUM_CONST = 16'hA5A5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  logic [31:0] src_ip,
   input  logic [31:0] dst_ip,
   input  logic [15:0] src_port,
   input  logic [15:0] dst_port,
   input  logic [15:0] udp_len,
   input  logic        add_en,
   input  logic        add_lo,
   input  logic [7:0]  add_byte,
   output logic [15:0] sum
);

   localparam int N_SEED = 10;

   logic [N_SEED-1:0][15:0] seed_w;
   logic [N_SEED:0][15:0]   chain;
   logic [15:0]             add_w;

   // pseudo-header words plus UDP header words (order is irrelevant to the sum)
   assign seed_w = {CSUM_CONST, udp_len, dst_port, src_port,
                    udp_len, IP_PROTO_UDP,
                    dst_ip[15:0], dst_ip[31:16],
                    src_ip[15:0], src_ip[31:16]};

   assign chain[0] = 16'h0000;

   generate
      for (genvar i = 0; i < N_SEED; i++) begin : g_fold
         assign chain[i+1] = oc_add(chain[i], seed_w[i]);
      end
   endgenerate

   // even byte index is the high half of a big-endian pair
   assign add_w = add_lo ? {8'h00, add_byte} : {add_byte, 8'h00};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum <= 16'h0000;
      end else if (load) begin
         sum <= chain[N_SEED];
      end else if (add_en) begin
         sum <= oc_add(sum, add_w);
      end
   end

   // R4: the sum moves only on a seed load or an accepted payload byte
   a_r4_sum_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !add_en) |=> $stable(sum));

   // R4: a seed containing a non-zero constant never folds to zero
   a_r4_seed_nonzero : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (sum != 16'h0000));

endmodule

// File: rtl/udp_stx_hdr.sv
module udp_stx_hdr #(
   parameter logic [15:0] CSUM_CONST = 16'hA5A5
) (
   input  logic [15:0] src_port,
   input  logic [15:0] dst_port,
   input  logic [15:0] udp_len,
   input  logic [2:0]  idx,
   output logic [7:0]  hdr_byte
);

   localparam int N_WORDS = 4;

   logic [N_WORDS-1:0][15:0]   words;
   logic [2*N_WORDS-1:0][7:0]  bytes_a;

   // words[0] goes out first
   assign words = {CSUM_CONST, udp_len, dst_port, src_port};

   generate
      for (genvar w = 0; w < N_WORDS; w++) begin : g_split
         assign bytes_a[2*w]   = words[w][15:8];
         assign bytes_a[2*w+1] = words[w][7:0];
      end
   endgenerate

   assign hdr_byte = bytes_a[idx];

endmodule

// File: rtl/udp_stx_ctrl.sv
module udp_stx_ctrl
   import udp_stx_pkg::*;
#(
   parameter int LEN_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [LEN_W-1:0] cmd_pay_len,
   input  logic             in_valid,
   input  logic             out_ready,
   output stx_state_e       state,
   output logic [2:0]       hdr_idx,
   output logic             cnt_lsb,
   output logic             cmd_fire,
   output logic             out_fire
);

   localparam logic [LEN_W-1:0] HDR_LAST = LEN_W'(UDP_HDR_BYTES - 1);
   localparam logic [LEN_W-1:0] ONE      = LEN_W'(1);

   logic [LEN_W-1:0] cnt;
   logic [LEN_W-1:0] pay_len_q;

   assign cmd_fire = (state == ST_IDLE) && cmd_valid;
   assign out_fire = out_ready &&
                     ((state == ST_HDR) || (state == ST_TRL) ||
                      ((state == ST_PAY) && in_valid));
   assign hdr_idx  = cnt[2:0];
   assign cnt_lsb  = cnt[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         pay_len_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (cmd_valid) begin
                  state     <= ST_HDR;
                  cnt       <= '0;
                  pay_len_q <= cmd_pay_len & ~ONE;
               end
            end
            ST_HDR: begin
               if (out_fire) begin
                  if (cnt == HDR_LAST) begin
                     cnt   <= '0;
                     state <= (pay_len_q == '0) ? ST_TRL : ST_PAY;
                  end else begin
                     cnt <= cnt + ONE;
                  end
               end
            end
            ST_PAY: begin
               if (out_fire) begin
                  if (cnt == pay_len_q - ONE) begin
                     cnt   <= '0;
                     state <= ST_TRL;
                  end else begin
                     cnt <= cnt + ONE;
                  end
               end
            end
            ST_TRL: begin
               if (out_fire) begin
                  if (cnt[0]) begin
                     cnt   <= '0;
                     state <= ST_IDLE;
                  end else begin
                     cnt <= cnt + ONE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R1: every phase begins counting from its first byte
   a_r1_phase_from_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (state != $past(state)) |-> (cnt == '0));

   // R7: the payload phase is never entered for an empty payload
   a_r7_no_empty_pay : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PAY) |-> (pay_len_q != '0));

   // R3: the payload counter stays inside the commanded length
   a_r3_pay_bound : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PAY) |-> (cnt < pay_len_q));

endmodule

// File: rtl/udp_stream_tx.sv
module udp_stream_tx
   import udp_stx_pkg::*;
#(
   parameter logic [15:0] CSUM_CONST = 16'hA5A5,
   parameter int          LEN_W      = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [31:0]      cmd_src_ip,
   input  logic [31:0]      cmd_dst_ip,
   input  logic [15:0]      cmd_src_port,
   input  logic [15:0]      cmd_dst_port,
   input  logic [LEN_W-1:0] cmd_pay_len,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [7:0]       in_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [7:0]       out_data,
   output logic             out_last
);

   localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);
   localparam logic [15:0]      LEN_OVH = 16'(UDP_HDR_BYTES + TRL_BYTES);

   generate
      if (CSUM_CONST == 16'h0000) begin : g_bad_const
         $error("CSUM_CONST of zero marks a datagram as unchecked");
      end
      if (LEN_W < 3 || LEN_W > 15) begin : g_bad_len_w
         $error("LEN_W must lie in 3..15 so the UDP length fits 16 bits");
      end
   endgenerate

   stx_state_e  state;
   logic [2:0]  hdr_idx;
   logic        cnt_lsb;
   logic        cmd_fire;
   logic        out_fire;
   logic [15:0] sum;
   logic [15:0] trailer;
   logic [7:0]  hdr_byte;
   logic [15:0] cmd_udp_len;
   logic [15:0] sp_q, dp_q, ulen_q;
   logic        add_en;

   assign cmd_udp_len = 16'(cmd_pay_len & ~ONE) + LEN_OVH;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_q   <= 16'h0000;
         dp_q   <= 16'h0000;
         ulen_q <= 16'h0000;
      end else if (cmd_fire) begin
         sp_q   <= cmd_src_port;
         dp_q   <= cmd_dst_port;
         ulen_q <= cmd_udp_len;
      end
   end

   udp_stx_ctrl #(.LEN_W(LEN_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_pay_len(cmd_pay_len),
      .in_valid   (in_valid),
      .out_ready  (out_ready),
      .state      (state),
      .hdr_idx    (hdr_idx),
      .cnt_lsb    (cnt_lsb),
      .cmd_fire   (cmd_fire),
      .out_fire   (out_fire)
   );

   udp_stx_hdr #(.CSUM_CONST(CSUM_CONST)) u_hdr (
      .src_port(sp_q),
      .dst_port(dp_q),
      .udp_len (ulen_q),
      .idx     (hdr_idx),
      .hdr_byte(hdr_byte)
   );

   assign add_en = (state == ST_PAY) && out_fire;

   udp_stx_csum #(.CSUM_CONST(CSUM_CONST)) u_csum (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cmd_fire),
      .src_ip  (cmd_src_ip),
      .dst_ip  (cmd_dst_ip),
      .src_port(cmd_src_port),
      .dst_port(cmd_dst_port),
      .udp_len (cmd_udp_len),
      .add_en  (add_en),
      .add_lo  (cnt_lsb),
      .add_byte(in_data),
      .sum     (sum)
   );

   assign trailer   = ~sum;
   assign cmd_ready = (state == ST_IDLE);

   always_comb begin
      out_valid = 1'b0;
      out_data  = 8'h00;
      out_last  = 1'b0;
      in_ready  = 1'b0;
      unique case (state)
         ST_HDR: begin
            out_valid = 1'b1;
            out_data  = hdr_byte;
         end
         ST_PAY: begin
            out_valid = in_valid;
            out_data  = in_data;
            in_ready  = out_ready;
         end
         ST_TRL: begin
            out_valid = 1'b1;
            out_data  = cnt_lsb ? trailer[7:0] : trailer[15:8];
            out_last  = cnt_lsb;
         end
         default: ;
      endcase
   end

   // R5: the last flag only marks a byte that is offered
   a_r5_last_valid : assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   // R5/R9: after the final byte leaves, the block is idle again
   a_r5_idle_after_last : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> cmd_ready);

   // R9: no command is taken while bytes are moving
   a_r9_no_overlap : assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (!out_valid && !in_ready));

   // R6: a stalled header or trailer byte is held
   a_r6_stall_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && (state != ST_PAY)) |=> (out_valid && $stable(out_data)));

   // R3: a payload byte is taken only when the sink takes it too
   a_r3_in_follows_out : assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> out_ready);

endmodule

// File: tb/udp_stream_tx_tb.sv
module udp_stream_tx_tb;

   localparam logic [15:0] CONST_V = 16'hA5A5;
   localparam int          LEN_W   = 11;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_valid = 1'b0;
   logic             cmd_ready;
   logic [31:0]      cmd_src_ip = '0;
   logic [31:0]      cmd_dst_ip = '0;
   logic [15:0]      cmd_src_port = '0;
   logic [15:0]      cmd_dst_port = '0;
   logic [LEN_W-1:0] cmd_pay_len = '0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [7:0]       in_data = '0;
   logic             out_valid;
   logic             out_ready = 1'b1;
   logic [7:0]       out_data;
   logic             out_last;

   always #5 clk = ~clk;

   udp_stream_tx #(.CSUM_CONST(CONST_V), .LEN_W(LEN_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_src_ip(cmd_src_ip), .cmd_dst_ip(cmd_dst_ip),
      .cmd_src_port(cmd_src_port), .cmd_dst_port(cmd_dst_port),
      .cmd_pay_len(cmd_pay_len),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_last(out_last)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int done_cnt = 0;
   bit bp_en = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   logic [7:0]  exp_d[$];
   bit          exp_l[$];
   logic [31:0] d_src[$];
   logic [31:0] d_dst[$];
   int          d_len[$];

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ocs(input logic [15:0] a, input logic [15:0] b);
      logic [16:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[15:0] + {15'd0, s[16]};
   endfunction

   function automatic logic [7:0] pay_byte(input int seed, input int i);
      return 8'((seed * 37 + i * 11) ^ (i >> 2));
   endfunction

   // sink backpressure pattern
   always @(negedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready <= bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
   end

   // monitor / scoreboard
   logic [7:0] rx_buf[$];
   bit         prev_stall = 1'b0;
   logic [7:0] prev_data = '0;

   always @(negedge clk) begin
      #4;
      if (rst_n) begin
         if (prev_stall) begin
            chk(out_valid && (out_data == prev_data), "R6 stalled byte held",
                {23'd0, out_valid, out_data}, {24'd1, prev_data});
         end
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
         if (out_valid && out_ready) begin
            if (exp_d.size() == 0) begin
               chk(1'b0, "R3 unexpected output byte", {24'd0, out_data}, 32'd0);
            end else begin
               logic [7:0] ed;
               bit el;
               int idx;
               int plen;
               string tag;
               ed = exp_d.pop_front();
               el = exp_l.pop_front();
               idx = rx_buf.size();
               plen = d_len[0];
               if (idx == 0) chk(cmd_ready == 1'b0, "R9 cmd_ready low in datagram", {31'd0, cmd_ready}, 32'd0);
               if (idx < 6) tag = "R1 header byte";
               else if (idx < 8) tag = "R2 checksum field";
               else if (idx < 8 + plen) tag = "R3 payload byte";
               else tag = "R4 trailer byte";
               chk(out_data == ed, tag, {24'd0, out_data}, {24'd0, ed});
               chk(out_last == el, "R5 last flag", {31'd0, out_last}, {31'd0, el});
               rx_buf.push_back(out_data);
               if (out_last) begin
                  logic [15:0] acc;
                  logic [31:0] s_ip, d_ip;
                  int n;
                  s_ip = d_src.pop_front();
                  d_ip = d_dst.pop_front();
                  n = d_len.pop_front();
                  chk(rx_buf.size() == n + 10, "R8 datagram byte count",
                      rx_buf.size(), n + 10);
                  chk({rx_buf[4], rx_buf[5]} == 16'(n + 10), "R1 UDP length field",
                      {16'd0, rx_buf[4], rx_buf[5]}, n + 10);
                  chk({rx_buf[6], rx_buf[7]} == CONST_V, "R2 constant in header",
                      {16'd0, rx_buf[6], rx_buf[7]}, {16'd0, CONST_V});
                  acc = 16'h0;
                  acc = ocs(acc, s_ip[31:16]);
                  acc = ocs(acc, s_ip[15:0]);
                  acc = ocs(acc, d_ip[31:16]);
                  acc = ocs(acc, d_ip[15:0]);
                  acc = ocs(acc, 16'h0011);
                  acc = ocs(acc, 16'(rx_buf.size()));
                  for (int k = 0; k + 1 < rx_buf.size(); k += 2)
                     acc = ocs(acc, {rx_buf[k], rx_buf[k+1]});
                  chk(acc == 16'hFFFF, "R4 receiver checksum verifies",
                      {16'd0, acc}, 32'h0000FFFF);
                  rx_buf.delete();
                  done_cnt++;
               end
            end
         end
      end
   end

   task automatic send_payload(input int n, input int seed, input bit gaps);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (gaps && i > 0 && (i % 3 == 0)) begin
            in_valid = 1'b0;
            #4;
            chk(out_valid == 1'b0, "R11 source pause shows no byte", {31'd0, out_valid}, 32'd0);
            @(negedge clk);
         end
         in_valid = 1'b1;
         in_data  = pay_byte(seed, i);
         #4;
         while (!in_ready) begin
            @(negedge clk);
            #4;
         end
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic run_pkt(input logic [31:0] sip, input logic [31:0] dip,
                          input logic [15:0] sp, input logic [15:0] dp,
                          input int len, input int seed, input bit gaps);
      int ev;
      int tgt;
      logic [15:0] acc;
      logic [15:0] ul;
      logic [7:0]  hb[8];
      ev  = len & ~1;
      ul  = 16'(ev + 10);
      tgt = done_cnt + 1;
      hb = '{sp[15:8], sp[7:0], dp[15:8], dp[7:0], ul[15:8], ul[7:0], CONST_V[15:8], CONST_V[7:0]};
      acc = 16'h0;
      acc = ocs(acc, sip[31:16]);
      acc = ocs(acc, sip[15:0]);
      acc = ocs(acc, dip[31:16]);
      acc = ocs(acc, dip[15:0]);
      acc = ocs(acc, 16'h0011);
      acc = ocs(acc, ul);
      for (int k = 0; k < 8; k++) begin
         exp_d.push_back(hb[k]);
         exp_l.push_back(1'b0);
      end
      for (int k = 0; k < 8; k += 2) acc = ocs(acc, {hb[k], hb[k+1]});
      for (int k = 0; k < ev; k++) begin
         exp_d.push_back(pay_byte(seed, k));
         exp_l.push_back(1'b0);
      end
      for (int k = 0; k < ev; k += 2) acc = ocs(acc, {pay_byte(seed, k), pay_byte(seed, k + 1)});
      exp_d.push_back(~acc[15:8]);
      exp_l.push_back(1'b0);
      exp_d.push_back(~acc[7:0]);
      exp_l.push_back(1'b1);
      d_src.push_back(sip);
      d_dst.push_back(dip);
      d_len.push_back(ev);

      @(negedge clk);
      cmd_src_ip   = sip;
      cmd_dst_ip   = dip;
      cmd_src_port = sp;
      cmd_dst_port = dp;
      cmd_pay_len  = LEN_W'(len);
      cmd_valid    = 1'b1;
      #4;
      while (!cmd_ready) begin
         @(negedge clk);
         #4;
      end
      @(posedge clk);
      @(negedge clk);
      cmd_valid    = 1'b0;
      cmd_src_ip   = 32'hDEAD_BEEF;
      cmd_src_port = 16'hFFFF;
      send_payload(ev, seed, gaps);
      while (done_cnt < tgt) @(negedge clk);
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #4;
      // R10: reset state
      chk(cmd_ready == 1'b1, "R10 cmd_ready after reset", {31'd0, cmd_ready}, 32'd1);
      chk(out_valid == 1'b0, "R10 out_valid after reset", {31'd0, out_valid}, 32'd0);
      chk(in_ready == 1'b0, "R10 in_ready after reset", {31'd0, in_ready}, 32'd0);

      // R1 R3 R4: plain datagram, steady sink
      run_pkt(32'hC0A8_0001, 32'hC0A8_0002, 16'd5000, 16'd6000, 8, 1, 1'b0);
      // R7: empty payload
      run_pkt(32'h0A00_0001, 32'h0A00_00FE, 16'h1234, 16'h0035, 0, 2, 1'b0);
      // R8: odd count rounded down
      run_pkt(32'hAC10_0505, 32'hAC10_0A0A, 16'hFFFF, 16'h0001, 7, 3, 1'b0);
      // R6: stalling sink on the same payload as packet 1
      bp_en = 1'b1;
      run_pkt(32'hC0A8_0001, 32'hC0A8_0002, 16'd5000, 16'd6000, 8, 1, 1'b0);
      run_pkt(32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 16'hFFFF, 64, 4, 1'b0);
      // R11: pausing source with stalling sink
      run_pkt(32'h0102_0304, 32'h0506_0708, 16'h0BAD, 16'hF00D, 30, 5, 1'b1);
      // long datagram near the largest count
      run_pkt(32'h7F00_0001, 32'h7F00_0001, 16'd80, 16'd8080, 2046, 6, 1'b0);
      bp_en = 1'b0;
      run_pkt(32'h0000_0000, 32'h0000_0000, 16'h0000, 16'h0000, 2, 0, 1'b1);

      repeat (4) @(negedge clk);
      chk(exp_d.size() == 0, "R3 all expected bytes seen", exp_d.size(), 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule